// File: doc/BRIEF.md
# Bit-band alias access bridge

This bridge sits behind a 32 MB alias window. Each word-sized location in that window stands for one bit of a 1 MB backing region. A request on the slave side gives an address, a size code and, for writes, a data word. The bridge then runs the matching access or accesses on its master side.

A read returns the selected backing bit as 0 or 1. A write becomes a locked read-modify-write that sets or clears that one bit and leaves every other bit of the backing location as it was. The backing base address and the alias window base are elaboration parameters. One instance serves each alias/backing pair.

Backing data on the master bus is little-endian and right-aligned to the access size. Bit n of a halfword or word value therefore lies in byte n/8 at position n%8.

Top module: `bitband_bridge`

## Requirements
- R1: The master address is BACK_BASE OR'd with alias address bits [24:5]. Address bits above bit 24 have no effect.
- R2: The size code is 0 for byte, 1 for halfword and 2 for word, and 3 is handled as word. The master access carries the request's size. A halfword access clears address bit 0, and a word access clears address bits [1:0].
- R3: The selected bit number is alias address bits [4:2] for a byte, [5:2] for a halfword and [6:2] for a word. It counts from bit 0 of the right-aligned master data value.
- R4: When a read completes, `s_rdata` holds the selected bit in bit 0 and zeros in bits 31:1. When a write completes, `s_rdata` is zero.
- R5: A write performs one master read and then one master write, to the same address and at the same size. The selected bit takes the value of `s_wdata` bit 0, and all other bits keep the value that was read. Write-data bits 31:1 are ignored.
- R6: A read request causes exactly one master read and no master write.
- R7: `m_lock` is high on both master accesses of a write and stays high between them. The write-back is issued in the cycle right after the read completes.
- R8: The master holds `m_valid`, the address, the direction and the lock stable until `m_ready`. `s_ready` is a single-cycle pulse that comes only after the last master access has completed, and never while `m_valid` is high.
- R9: During reset, `s_ready`, `m_valid` and `m_lock` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Request valid; held until s_ready |
| s_ready | output | 1 | One-cycle completion pulse |
| s_write | input | 1 | 1 = write, 0 = read |
| s_size | input | 2 | Size code: 0 byte, 1 halfword, 2 word |
| s_addr | input | ADDR_W | Alias address |
| s_wdata | input | DATA_W | Write data; only bit 0 is used |
| s_rdata | output | DATA_W | Read result, valid with s_ready |
| m_valid | output | 1 | Backing access valid |
| m_ready | input | 1 | Backing access completes this cycle |
| m_write | output | 1 | Backing access is a write |
| m_lock | output | 1 | Held across the read-modify-write |
| m_size | output | 2 | Backing access size code |
| m_addr | output | ADDR_W | Backing byte address |
| m_wdata | output | DATA_W | Right-aligned write-back value |
| m_rdata | input | DATA_W | Right-aligned read value, valid with m_ready |

## Verification
The bench sweeps every alias word that covers a 64-byte backing window, at all three sizes. It does this for reads, and for writes that both set and clear, against a reference bit array.

A mapping that mixes up byte order or takes the bit index from the wrong address bits returns the wrong bit. It also corrupts the wrong position, so the full-memory comparison after each write catches it.

Clear-writes use data with bits 31:1 all set. A design that tests any bit other than bit 0 would set the bit instead of clearing it.

The bench also checks the following:
- Alias addresses carry garbage above bit 24, so a decoder that does not drop those bits sends its access outside the window.
- The master access count of every request is checked, so an extra write on a read, or a missing write-back, is reported.
- The lock is captured on both halves of each write.

// File: rtl/bb_pkg.sv
package bb_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } bb_size_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RD,
      ST_WR,
      ST_DONE
   } bb_state_e;

   function automatic bb_size_e bb_norm_size(input logic [1:0] code);
      case (code)
         2'd0:    return SZ_BYTE;
         2'd1:    return SZ_HALF;
         default: return SZ_WORD;
      endcase
   endfunction

endpackage

// File: rtl/bb_addr_map.sv
module bb_addr_map
   import bb_pkg::*;
#(
   parameter int                ADDR_W    = 32,
   parameter int                SPAN_BITS = 25,
   parameter logic [ADDR_W-1:0] BACK_BASE = 32'h2000_0000
) (
   input  logic [ADDR_W-1:0] alias_addr,
   input  bb_size_e          size,
   output logic [ADDR_W-1:0] back_addr,
   output logic [4:0]        bit_idx
);
   localparam int SEL_W = SPAN_BITS - 5;

   logic [SEL_W-1:0]  word_sel;
   logic [ADDR_W-1:0] raw_addr;

   assign word_sel = alias_addr[SPAN_BITS-1:5];
   assign raw_addr = BACK_BASE | ADDR_W'(word_sel);

   always_comb begin
      case (size)
         SZ_BYTE: begin
            back_addr = raw_addr;
            bit_idx   = {2'b00, alias_addr[4:2]};
         end
         SZ_HALF: begin
            back_addr = {raw_addr[ADDR_W-1:1], 1'b0};
            bit_idx   = {1'b0, alias_addr[5:2]};
         end
         default: begin
            back_addr = {raw_addr[ADDR_W-1:2], 2'b00};
            bit_idx   = alias_addr[6:2];
         end
      endcase
   end
endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge
   import bb_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] old_data,
   input  bb_size_e          size,
   input  logic [4:0]        bit_idx,
   input  logic              set_val,
   output logic              bit_out,
   output logic [DATA_W-1:0] new_data
);
   localparam int LANES = DATA_W / 8;

   logic [LANES-1:0] lane_live;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane_live[l] = (32'(l) < (32'd1 << size));
   end

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      logic hit;
      assign hit         = (5'(i) == bit_idx);
      assign new_data[i] = lane_live[i/8] & (hit ? set_val : old_data[i]);
   end

   assign bit_out = old_data[bit_idx];
endmodule

// File: rtl/bb_seq.sv
module bb_seq
   import bb_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_valid,
   input  logic              s_write,
   input  logic [1:0]        s_size,
   input  logic              s_set,
   input  logic [ADDR_W-1:0] map_addr,
   input  logic [4:0]        map_idx,
   output logic              s_ready,
   output logic [DATA_W-1:0] s_rdata,
   output bb_size_e          cap_size,
   output logic [4:0]        cap_idx,
   output logic              cap_set,
   input  logic              mrg_bit,
   input  logic [DATA_W-1:0] mrg_data,
   output logic              m_valid,
   input  logic              m_ready,
   output logic              m_write,
   output logic              m_lock,
   output logic [ADDR_W-1:0] m_addr,
   output logic [DATA_W-1:0] m_wdata
);
   bb_state_e         state;
   logic              cap_wr;
   logic [ADDR_W-1:0] cap_addr;
   logic              rbit_q;
   logic [DATA_W-1:0] wdat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cap_wr   <= 1'b0;
         cap_addr <= '0;
         cap_size <= SZ_BYTE;
         cap_idx  <= '0;
         cap_set  <= 1'b0;
         rbit_q   <= 1'b0;
         wdat_q   <= '0;
      end else begin
         case (state)
            ST_IDLE: if (s_valid) begin
               cap_wr   <= s_write;
               cap_addr <= map_addr;
               cap_size <= bb_norm_size(s_size);
               cap_idx  <= map_idx;
               cap_set  <= s_set;
               state    <= ST_RD;
            end
            ST_RD: if (m_ready) begin
               rbit_q <= mrg_bit;
               wdat_q <= mrg_data;
               state  <= cap_wr ? ST_WR : ST_DONE;
            end
            ST_WR: if (m_ready) state <= ST_DONE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign m_valid = (state == ST_RD) || (state == ST_WR);
   assign m_write = (state == ST_WR);
   assign m_lock  = cap_wr && m_valid;
   assign m_addr  = cap_addr;
   assign m_wdata = m_write ? wdat_q : '0;
   assign s_ready = (state == ST_DONE);
   assign s_rdata = (s_ready && !cap_wr) ? DATA_W'(rbit_q) : '0;
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
   import bb_pkg::*;
#(
   parameter int                ADDR_W     = 32,
   parameter int                DATA_W     = 32,
   parameter int                SPAN_BITS  = 25,
   parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'h2200_0000,
   parameter logic [ADDR_W-1:0] BACK_BASE  = 32'h2000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_valid,
   output logic              s_ready,
   input  logic              s_write,
   input  logic [1:0]        s_size,
   input  logic [ADDR_W-1:0] s_addr,
   input  logic [DATA_W-1:0] s_wdata,
   output logic [DATA_W-1:0] s_rdata,
   output logic              m_valid,
   input  logic              m_ready,
   output logic              m_write,
   output logic              m_lock,
   output logic [1:0]        m_size,
   output logic [ADDR_W-1:0] m_addr,
   output logic [DATA_W-1:0] m_wdata,
   input  logic [DATA_W-1:0] m_rdata
);
   localparam int BACK_SPAN = SPAN_BITS - 5;
   localparam logic [ADDR_W-1:0] ALIAS_LOW = (ADDR_W'(1) << SPAN_BITS) - 1;
   localparam logic [ADDR_W-1:0] BACK_LOW  = (ADDR_W'(1) << BACK_SPAN) - 1;

   initial begin
      assert (DATA_W == 32) else $error("bitband_bridge: DATA_W must be 32");
      assert (SPAN_BITS > 7 && SPAN_BITS < ADDR_W)
         else $error("bitband_bridge: SPAN_BITS out of range");
      assert ((ALIAS_BASE & ALIAS_LOW) == '0)
         else $error("bitband_bridge: ALIAS_BASE not aligned to window");
      assert ((BACK_BASE & BACK_LOW) == '0)
         else $error("bitband_bridge: BACK_BASE not aligned to region");
   end

   logic [ADDR_W-1:0] map_addr;
   logic [4:0]        map_idx;
   bb_size_e          cap_size;
   logic [4:0]        cap_idx;
   logic              cap_set;
   logic              mrg_bit;
   logic [DATA_W-1:0] mrg_data;

   bb_addr_map #(
      .ADDR_W(ADDR_W), .SPAN_BITS(SPAN_BITS), .BACK_BASE(BACK_BASE)
   ) u_map (
      .alias_addr(s_addr),
      .size      (bb_norm_size(s_size)),
      .back_addr (map_addr),
      .bit_idx   (map_idx)
   );

   bb_bit_merge #(.DATA_W(DATA_W)) u_merge (
      .old_data(m_rdata),
      .size    (cap_size),
      .bit_idx (cap_idx),
      .set_val (cap_set),
      .bit_out (mrg_bit),
      .new_data(mrg_data)
   );

   bb_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .s_valid (s_valid),
      .s_write (s_write),
      .s_size  (s_size),
      .s_set   (s_wdata[0]),
      .map_addr(map_addr),
      .map_idx (map_idx),
      .s_ready (s_ready),
      .s_rdata (s_rdata),
      .cap_size(cap_size),
      .cap_idx (cap_idx),
      .cap_set (cap_set),
      .mrg_bit (mrg_bit),
      .mrg_data(mrg_data),
      .m_valid (m_valid),
      .m_ready (m_ready),
      .m_write (m_write),
      .m_lock  (m_lock),
      .m_addr  (m_addr),
      .m_wdata (m_wdata)
   );

   assign m_size = cap_size;
endmodule

// File: rtl/bb_checker.sv
module bb_checker #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              s_ready,
   input logic [DATA_W-1:0] s_rdata,
   input logic              m_valid,
   input logic              m_ready,
   input logic              m_write,
   input logic              m_lock,
   input logic [1:0]        m_size,
   input logic [ADDR_W-1:0] m_addr
);
   logic [ADDR_W-1:0] rd_addr_q;
   logic [1:0]        rd_size_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_addr_q <= '0;
         rd_size_q <= '0;
      end else if (m_valid && m_ready && !m_write) begin
         rd_addr_q <= m_addr;
         rd_size_q <= m_size;
      end
   end

   p_word_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid && m_size == 2'd2 |-> m_addr[1:0] == 2'b00);
   p_half_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid && m_size == 2'd1 |-> m_addr[0] == 1'b0);
   p_rdata_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready |-> s_rdata[DATA_W-1:1] == '0);
   p_wb_same_r5: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid && m_write |-> m_addr == rd_addr_q && m_size == rd_size_q);
   p_wb_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid && m_write |-> m_lock);
   p_wb_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid && m_ready && !m_write && m_lock |=> m_valid && m_write && m_lock);
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid && !m_ready |=> m_valid && $stable(m_addr) && $stable(m_write) && $stable(m_lock));
   p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready |=> !s_ready);
   p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid |-> !s_ready);
endmodule

bind bitband_bridge bb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .s_ready(s_ready),
   .s_rdata(s_rdata),
   .m_valid(m_valid),
   .m_ready(m_ready),
   .m_write(m_write),
   .m_lock (m_lock),
   .m_size (m_size),
   .m_addr (m_addr)
);

// File: tb/tb_bitband_bridge.sv
module tb_bitband_bridge;
   localparam logic [31:0] ALIAS = 32'h2200_0000;
   localparam logic [31:0] BACK  = 32'h2000_0000;
   localparam int NBYTES = 64;
   localparam int NBITS  = NBYTES * 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        s_valid = 1'b0, s_write = 1'b0;
   logic [1:0]  s_size = 2'd0;
   logic [31:0] s_addr = '0, s_wdata = '0;
   logic        s_ready, m_valid, m_write, m_lock, m_ready;
   logic [1:0]  m_size;
   logic [31:0] s_rdata, m_addr, m_wdata, m_rdata;

   always #10 clk = ~clk;

   bitband_bridge #(.ALIAS_BASE(ALIAS), .BACK_BASE(BACK)) dut (
      .clk(clk), .rst_n(rst_n),
      .s_valid(s_valid), .s_ready(s_ready), .s_write(s_write), .s_size(s_size),
      .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata),
      .m_valid(m_valid), .m_ready(m_ready), .m_write(m_write), .m_lock(m_lock),
      .m_size(m_size), .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata)
   );

   // behavioural backing memory
   logic [7:0]  mem [NBYTES];
   logic [2:0]  stall;
   int          rd_cnt, wr_cnt, oob_cnt;
   logic [31:0] lrd_addr, lwr_addr;
   logic [1:0]  lrd_size, lwr_size;
   logic        lrd_lock, lwr_lock;
   int          cyc;

   function automatic logic [7:0] pat(input int i);
      return 8'(i * 37 + 5);
   endfunction

   assign m_ready = (stall == 3'd0);

   always_comb begin
      logic [5:0] a;
      a = m_addr[5:0];
      case (m_size)
         2'd0:    m_rdata = {24'h0, mem[a]};
         2'd1:    m_rdata = {16'h0, mem[6'(a + 1)], mem[a]};
         default: m_rdata = {mem[6'(a + 3)], mem[6'(a + 2)], mem[6'(a + 1)], mem[a]};
      endcase
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         for (int i = 0; i < NBYTES; i++) mem[i] <= pat(i);
         stall <= 3'd0;
         rd_cnt <= 0; wr_cnt <= 0; oob_cnt <= 0;
      end else if (m_valid && m_ready) begin
         stall <= 3'(cyc % 3);
         if (m_addr[31:6] != BACK[31:6]) oob_cnt <= oob_cnt + 1;
         if (m_write) begin
            wr_cnt <= wr_cnt + 1; lwr_addr <= m_addr; lwr_size <= m_size; lwr_lock <= m_lock;
            mem[m_addr[5:0]] <= m_wdata[7:0];
            if (m_size != 2'd0) mem[6'(m_addr[5:0] + 1)] <= m_wdata[15:8];
            if (m_size == 2'd2) begin
               mem[6'(m_addr[5:0] + 2)] <= m_wdata[23:16];
               mem[6'(m_addr[5:0] + 3)] <= m_wdata[31:24];
            end
         end else begin
            rd_cnt <= rd_cnt + 1; lrd_addr <= m_addr; lrd_size <= m_size; lrd_lock <= m_lock;
         end
      end else if (stall != 3'd0) begin
         stall <= stall - 3'd1;
      end
   end

   int total = 0, bad = 0;
   logic refb [NBITS];

   task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic do_req(input logic wr, input logic [31:0] addr, input logic [31:0] wd,
                         input logic [1:0] sz, output logic [31:0] rd);
      @(negedge clk);
      s_valid = 1'b1; s_write = wr; s_addr = addr; s_wdata = wd; s_size = sz;
      do @(negedge clk); while (!s_ready);
      rd = s_rdata;
      @(negedge clk);
      s_valid = 1'b0;
   endtask

   function automatic logic [31:0] exp_addr(input int w, input int sz);
      logic [31:0] a;
      a = BACK | 32'(w >> 3);
      if (sz == 1) a[0] = 1'b0;
      if (sz == 2) a[1:0] = 2'b00;
      return a;
   endfunction

   initial begin
      logic [31:0] rd;
      int r0, w0;
      cyc = 0;
      for (int i = 0; i < NBITS; i++) refb[i] = pat(i / 8)[i % 8];
      repeat (3) @(negedge clk);
      // R9: reset state
      chk(s_ready == 1'b0, "R9 s_ready in reset", 32'(s_ready), 32'd0);
      chk(m_valid == 1'b0, "R9 m_valid in reset", 32'(m_valid), 32'd0);
      chk(m_lock == 1'b0, "R9 m_lock in reset", 32'(m_lock), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // read sweep over every alias word and size
      for (int sz = 0; sz < 3; sz++) begin
         for (int w = 0; w < NBITS; w++) begin
            logic [31:0] a;
            a = {7'(w * 13 + sz + 1), 25'(w * 4 + (w & 3))};
            r0 = rd_cnt; w0 = wr_cnt;
            do_req(1'b0, a, 32'hFFFF_FFFF, 2'(sz), rd);
            // R3 R4: read returns the selected bit, upper bits zero
            chk(rd == 32'(refb[w]), "R4 R3 read bit", rd, 32'(refb[w]));
            // R1: address from bits 24:5, upper alias bits ignored
            chk(lrd_addr == exp_addr(w, sz), "R1 master read addr", lrd_addr, exp_addr(w, sz));
            chk(lrd_size == 2'(sz), "R2 master size", 32'(lrd_size), 32'(sz));
            // R6: one read, no write; R8: ready has dropped
            chk(rd_cnt - r0 == 1 && wr_cnt == w0, "R6 access count",
                32'((rd_cnt - r0) * 16 + (wr_cnt - w0)), 32'h10);
            chk(s_ready == 1'b0, "R8 ready pulse", 32'(s_ready), 32'd0);
         end
      end

      // write sweep: set and clear every bit, clear-data has upper bits set
      for (int sz = 0; sz < 3; sz++) begin
         for (int w = 0; w < NBITS; w++) begin
            logic [31:0] a, d;
            logic        setv;
            int          mism;
            setv = ((w * 7 + sz) % 3) != 0;
            d = setv ? (32'h1 | 32'(w << 8)) : 32'hFFFF_FFFE;
            a = {7'(w * 5 + sz), 25'(w * 4)};
            r0 = rd_cnt; w0 = wr_cnt;
            do_req(1'b1, a, d, 2'(sz), rd);
            refb[w] = setv;
            mism = 0;
            for (int k = 0; k < NBITS; k++) if (mem[k / 8][k % 8] !== refb[k]) mism++;
            // R5 R3: only the selected bit follows data bit 0
            chk(mism == 0, "R5 R3 memory image", 32'(mism), 32'd0);
            chk(rd_cnt - r0 == 1 && wr_cnt - w0 == 1, "R5 rmw count",
                32'((rd_cnt - r0) * 16 + (wr_cnt - w0)), 32'h11);
            chk(lwr_addr == exp_addr(w, sz) && lrd_addr == lwr_addr, "R1 R5 rmw addr",
                lwr_addr, exp_addr(w, sz));
            chk(lwr_size == 2'(sz) && lrd_size == 2'(sz), "R2 rmw size", 32'(lwr_size), 32'(sz));
            chk(lrd_lock && lwr_lock, "R7 lock held", 32'({lrd_lock, lwr_lock}), 32'h3);
            chk(rd == 32'd0, "R4 write returns zero", rd, 32'd0);
         end
      end

      // size code 3 behaves as word (R2)
      do_req(1'b0, ALIAS | 32'(37 * 4), 32'h0, 2'd3, rd);
      chk(rd == 32'(refb[37]), "R2 size 3 read", rd, 32'(refb[37]));
      chk(lrd_size == 2'd2 && lrd_addr == exp_addr(37, 2), "R2 size 3 addr", lrd_addr, exp_addr(37, 2));

      chk(oob_cnt == 0, "R1 accesses inside window", 32'(oob_cnt), 32'd0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL R8 watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule